// File: doc/BRIEF.md
# Processor Status-Flag Arithmetic Unit

This block is the arithmetic stage of a small 8-bit processor that also moves 16-bit register pairs. Each issued operation takes an operation code, two 16-bit operands and the current status byte, and one clock later it returns a 16-bit result and an updated status byte. The status byte holds four flags: zero, subtract, half-carry and carry.

The supported operations are:

- 8-bit add.
- 8-bit subtract.
- 8-bit compare.
- 16-bit pair add.
- Stack-pointer plus a signed byte offset.
- 16-bit increment and 16-bit decrement.

Each operation class takes its half-carry from its own bit position. The signed pointer add takes both carry flags from an unsigned add of the low bytes, whatever the sign of the offset.

The block also puts out a cycle count, which the issuing sequencer uses to pace the instruction. The signed pointer add reports 16 cycles and every other operation reports a shorter default. Decode, register storage and memory access sit outside the block.

Top module: `flag_alu`

## Requirements
- R1: Op code 0 (8-bit add) uses operand bytes a[7:0] and b[7:0]. The result is the 8-bit sum, with upper byte 0. Half-carry is set when the two low nibbles sum above 0xF. Carry is set on a carry out of bit 7. Zero is set when the 8-bit sum is 0. Subtract is cleared.
- R2: Op code 1 (8-bit subtract) returns a[7:0]-b[7:0] modulo 256, with upper byte 0. Subtract is set. Half-carry is set when a[3:0] < b[3:0]. Carry is set when a[7:0] < b[7:0]. Zero is set when the difference is 0.
- R3: Op code 2 (compare) sets the flags exactly as op code 1 does. The result output carries operand a unchanged rather than the difference.
- R4: Op code 3 (16-bit pair add) returns a+b modulo 65536. Subtract is cleared. Half-carry is set when a[11:0]+b[11:0] carries into bit 12. Carry is set on a carry out of bit 15. Zero passes through from the incoming status byte.
- R5: Op code 4 (pointer plus signed offset) returns a plus sign-extended b[7:0], modulo 65536. Zero and subtract are cleared. Carry is set when a[7:0]+b[7:0], added unsigned, exceeds 0xFF. Half-carry is set when a[3:0]+b[3:0] exceeds 0xF.
- R6: Op code 5 returns a+1 and op code 6 returns a-1, both wrapping modulo 65536. Both leave all four flags as they arrived.
- R7: The status byte is laid out as zero in bit 7, subtract in bit 6, half-carry in bit 5 and carry in bit 4. The low nibble of the status output always reads 0.
- R8: Result, status, cycle count and out_valid are registered. They update exactly one clock after a cycle with in_valid high. out_valid is high only in that cycle, and the other outputs hold their values while in_valid is low.
- R9: The cycle-count output reads SP_CYCLES (16) for op code 4 and BASE_CYCLES (4) for every other op code.
- R10: Op code 7 is reserved. It returns operand a unchanged and leaves all flags as they arrived.
- R11: A synchronous reset, rst, clears the result, status, cycle count and out_valid to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue strobe for one operation |
| op | input | 3 | Operation code |
| opa | input | 16 | First operand (pointer or pair value) |
| opb | input | 16 | Second operand (offset uses bits 7:0) |
| flags_in | input | 8 | Incoming status byte |
| out_valid | output | 1 | Result strobe, one clock after issue |
| result | output | 16 | Registered result |
| flags_out | output | 8 | Registered updated status byte |
| cycles | output | 5 | Registered cycle count for the sequencer |

## Verification
The assertions assume three things about the inputs:

- The reset is held across at least one rising edge before the first issue.
- op, opa, opb and flags_in are known values in every cycle that in_valid is high.
- Flag rules are checked one clock after an issue against the values captured at that issue.

The stimulus drives every input on the falling edge and sets in_valid for a single cycle per operation. Between issues it leaves at least one idle cycle, so each result can be observed before the next issue replaces it.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int CYC_W       = 5,
  parameter int SP_CYCLES   = 16,
  parameter int BASE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       op,
  input  logic [15:0]      opa,
  input  logic [15:0]      opb,
  input  logic [7:0]       flags_in,
  output logic             out_valid,
  output logic [15:0]      result,
  output logic [7:0]       flags_out,
  output logic [CYC_W-1:0] cycles
);

  localparam logic [2:0] OP_ADD8  = 3'd0;
  localparam logic [2:0] OP_SUB8  = 3'd1;
  localparam logic [2:0] OP_CMP8  = 3'd2;
  localparam logic [2:0] OP_ADD16 = 3'd3;
  localparam logic [2:0] OP_ADDSP = 3'd4;
  localparam logic [2:0] OP_INC16 = 3'd5;
  localparam logic [2:0] OP_DEC16 = 3'd6;

  localparam logic [CYC_W-1:0] CYC_SP   = CYC_W'(SP_CYCLES);
  localparam logic [CYC_W-1:0] CYC_BASE = CYC_W'(BASE_CYCLES);

  logic [8:0]  sum8, dif8;
  logic [4:0]  nib_sum;
  logic [16:0] sum16;
  logic [12:0] sum12;
  logic [15:0] sp_sum;

  assign sum8    = {1'b0, opa[7:0]} + {1'b0, opb[7:0]};
  assign dif8    = {1'b0, opa[7:0]} - {1'b0, opb[7:0]};
  assign nib_sum = {1'b0, opa[3:0]} + {1'b0, opb[3:0]};
  assign sum16   = {1'b0, opa} + {1'b0, opb};
  assign sum12   = {1'b0, opa[11:0]} + {1'b0, opb[11:0]};
  assign sp_sum  = opa + {{8{opb[7]}}, opb[7:0]};

  logic [15:0] nxt_res;
  logic        fz, fn, fh, fc;

  always_comb begin
    nxt_res = opa;
    fz = flags_in[7];
    fn = flags_in[6];
    fh = flags_in[5];
    fc = flags_in[4];
    unique case (op)
      OP_ADD8: begin
        nxt_res = {8'h00, sum8[7:0]};
        fz = (sum8[7:0] == 8'h00);
        fn = 1'b0;
        fh = nib_sum[4];
        fc = sum8[8];
      end
      OP_SUB8, OP_CMP8: begin
        nxt_res = (op == OP_SUB8) ? {8'h00, dif8[7:0]} : opa;
        fz = (dif8[7:0] == 8'h00);
        fn = 1'b1;
        fh = (opa[3:0] < opb[3:0]);
        fc = dif8[8];
      end
      OP_ADD16: begin
        nxt_res = sum16[15:0];
        fn = 1'b0;
        fh = sum12[12];
        fc = sum16[16];
      end
      OP_ADDSP: begin
        nxt_res = sp_sum;
        fz = 1'b0;
        fn = 1'b0;
        fh = nib_sum[4];
        fc = sum8[8];
      end
      OP_INC16: nxt_res = opa + 16'd1;
      OP_DEC16: nxt_res = opa - 16'd1;
      default:  nxt_res = opa;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= '0;
      cycles    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt_res;
        flags_out <= {fz, fn, fh, fc, 4'h0};
        cycles    <= (op == OP_ADDSP) ? CYC_SP : CYC_BASE;
      end
    end
  end

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int CYC_W     = 5,
  parameter int SP_CYCLES = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [2:0]       op,
  input logic [7:0]       flags_in,
  input logic             out_valid,
  input logic [7:0]       flags_out,
  input logic [CYC_W-1:0] cycles
);

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r7_low_nibble_zero: assert property (@(posedge clk) disable iff (rst)
    flags_out[3:0] == 4'h0);

  a_r1_add_clears_sub: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd0) |=> !flags_out[6]);

  a_r2_sub_sets_sub: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == 3'd1 || op == 3'd2)) |=> flags_out[6]);

  a_r4_zero_passthrough: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd3) |=> (flags_out[7] == $past(flags_in[7])) && !flags_out[6]);

  a_r5_sp_flags_cycles: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd4) |=> (flags_out[7:6] == 2'b00) && (cycles == CYC_W'(SP_CYCLES)));

  a_r6_incdec_flags_kept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == 3'd5 || op == 3'd6)) |=> flags_out == {$past(flags_in[7:4]), 4'h0});

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(flags_out) && $stable(cycles));

endmodule

bind flag_alu flag_alu_chk #(.CYC_W(CYC_W), .SP_CYCLES(SP_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .flags_in(flags_in),
  .out_valid(out_valid), .flags_out(flags_out), .cycles(cycles)
);

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [15:0] opa = '0, opb = '0;
  logic [7:0]  flags_in = '0;
  logic        out_valid;
  logic [15:0] result;
  logic [7:0]  flags_out;
  logic [4:0]  cycles;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  flag_alu u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
    .flags_in(flags_in), .out_valid(out_valid), .result(result),
    .flags_out(flags_out), .cycles(cycles)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [15:0] a, input logic [15:0] b, input logic [7:0] f);
    @(negedge clk);
    op = o; opa = a; opb = b; flags_in = f; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run(input string req, input logic [2:0] o, input logic [15:0] a, input logic [15:0] b,
                     input logic [7:0] f, input logic [15:0] eres, input logic [7:0] eflg, input logic [4:0] ecyc);
    issue(o, a, b, f);
    chk(req, "valid", out_valid, 1'b1);
    chk(req, "result", result, eres);
    chk(req, "flags", flags_out, eflg);
    chk(req, "cycles", cycles, ecyc);
  endtask

  task automatic t_reset();
    chk("R11", "valid", out_valid, 1'b0);
    chk("R11", "result", result, 16'h0);
    chk("R11", "flags", flags_out, 8'h0);
    chk("R11", "cycles", cycles, 5'd0);
  endtask

  task automatic t_add8();
    run("R1", 3'd0, 16'h000F, 16'h0001, 8'h00, 16'h0010, 8'h20, 5'd4);
    run("R1", 3'd0, 16'h12FF, 16'h3401, 8'h40, 16'h0000, 8'hB0, 5'd4);
    run("R1", 3'd0, 16'h0080, 16'h0080, 8'h00, 16'h0000, 8'h90, 5'd4);
  endtask

  task automatic t_sub8();
    run("R2", 3'd1, 16'h0010, 16'h0001, 8'h00, 16'h000F, 8'h60, 5'd4);
    run("R2", 3'd1, 16'h0000, 16'h0001, 8'h00, 16'h00FF, 8'h70, 5'd4);
    run("R2", 3'd1, 16'h0042, 16'h0042, 8'h30, 16'h0000, 8'hC0, 5'd4);
  endtask

  task automatic t_cmp();
    run("R3", 3'd2, 16'h1205, 16'h0007, 8'h00, 16'h1205, 8'h70, 5'd4);
    run("R3", 3'd2, 16'h0033, 16'h0033, 8'h00, 16'h0033, 8'hC0, 5'd4);
  endtask

  task automatic t_add16();
    run("R4", 3'd3, 16'h0FFF, 16'h0001, 8'h80, 16'h1000, 8'hA0, 5'd4);
    run("R4", 3'd3, 16'hFFFF, 16'h0001, 8'h40, 16'h0000, 8'h30, 5'd4);
    run("R4", 3'd3, 16'h8000, 16'h8000, 8'h00, 16'h0000, 8'h10, 5'd4);
  endtask

  task automatic t_addsp();
    run("R5", 3'd4, 16'h00FF, 16'h0001, 8'h00, 16'h0100, 8'h30, 5'd16);
    run("R5", 3'd4, 16'h1000, 16'h00FF, 8'hF0, 16'h0FFF, 8'h00, 5'd16);
    run("R5", 3'd4, 16'h0001, 16'h00FF, 8'hC0, 16'h0000, 8'h30, 5'd16);
    run("R5", 3'd4, 16'hFFF8, 16'h0008, 8'h00, 16'h0000, 8'h30, 5'd16);
  endtask

  task automatic t_incdec();
    run("R6", 3'd5, 16'hFFFF, 16'h0000, 8'hA0, 16'h0000, 8'hA0, 5'd4);
    run("R6", 3'd6, 16'h0000, 16'h0000, 8'h50, 16'hFFFF, 8'h50, 5'd4);
    run("R7", 3'd6, 16'h1234, 16'h0000, 8'hFF, 16'h1233, 8'hF0, 5'd4);
  endtask

  task automatic t_reserved();
    run("R10", 3'd7, 16'hBEEF, 16'h1111, 8'h90, 16'hBEEF, 8'h90, 5'd4);
  endtask

  task automatic t_timing();
    issue(3'd4, 16'h0010, 16'h0010, 8'h00);
    chk("R9", "cycles", cycles, 5'd16);
    @(negedge clk);
    opa = 16'h5555; op = 3'd0; flags_in = 8'hF0;
    chk("R8", "valid drop", out_valid, 1'b0);
    @(negedge clk);
    chk("R8", "result hold", result, 16'h0020);
    chk("R8", "flags hold", flags_out, 8'h00);
    chk("R8", "cycles hold", cycles, 5'd16);
  endtask

  task automatic t_reset_mid();
    issue(3'd0, 16'h0001, 16'h0001, 8'h00);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    t_reset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_add8();
    t_sub8();
    t_cmp();
    t_add16();
    t_addsp();
    t_incdec();
    t_reserved();
    t_timing();
    t_reset_mid();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule